// File: doc/BRIEF.md
# Multithreaded Issue-Queue Entry Allocator

This block keeps count of how many issue-queue entries each of up to four hardware threads holds, and decides how many each thread may hold at most. Each per-thread cap comes from one of three sharing modes. In the first mode every thread may use the whole queue. In the second mode the queue is split evenly among the active threads. In the third mode every thread gets a fixed percentage of the queue. The caps are registered and recomputed every cycle from the mode, the percentage and the active-thread mask. A change of any of these is therefore picked up on the next clock edge.

Dispatch logic raises one allocate pulse per thread for each entry it wants to fill. The issue or commit side returns entries one at a time through release pulses. A squash returns a batch of entries from one thread at once. The outputs are the free count and full flag of each thread, a flag showing the whole queue is full, and an error pulse when an allocate was refused. All of these are plain control and status pins. There is no valid/ready handshake: a refused allocate is reported through the error pulse and not by stalling.

Top module: `iq_entry_alloc`

## Requirements
- R1: While reset is held and on the first cycle after it, every thread's occupancy is 0 and every cap is TOTAL/NT (8 with the defaults). No thread is full, `queue_full` is 0 and `alloc_err` is 0.
- R2: With `share_mode` 0 (whole-queue mode), or with the unused code 3, every thread's cap is TOTAL.
- R3: With `share_mode` 1 (even split), each thread whose bit is set in `active_mask` gets a cap of TOTAL divided by the number of set bits, with integer division. Each thread whose bit is clear gets TOTAL/NT. When the mask is all zero, every cap keeps its previous value.
- R4: With `share_mode` 2 (percentage mode), every cap is floor(min(`thresh_pct`,100)*TOTAL/100). When exactly one bit of `active_mask` is set, that one thread's cap is TOTAL instead.
- R5: A change of `share_mode`, `thresh_pct` or `active_mask` has no effect on the outputs before the next rising clock edge. It shows in the outputs just after that edge.
- R6: Each thread's free count is its cap minus its occupancy, clamped at 0 when the occupancy is larger than the cap. `thread_full[t]` is 1 exactly when that free count is 0.
- R7: An accepted allocate adds one to that thread's occupancy at the next edge. When several threads allocate in the same cycle, the remaining global room goes to them in ascending thread order.
- R8: An allocate is refused when its thread's free count is 0 or when no global room is left. A refused allocate leaves that thread's occupancy unchanged. `alloc_err` is 1 in the cycle after any refusal, and 0 otherwise.
- R9: A release pulse takes one entry from its thread. A squash takes `squash_cnt` entries from thread `squash_tid`. The total taken from a thread in one cycle is clamped at its current occupancy. An accepted allocate in the same cycle is added after the clamp.
- R10: The sum of all occupancies never exceeds TOTAL. `queue_full` is 1 exactly when that sum equals TOTAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| share_mode | input | 2 | Sharing mode: 0 whole queue, 1 even split, 2 percentage, 3 same as 0 |
| thresh_pct | input | 7 | Percentage used by mode 2; values above 100 are treated as 100 |
| active_mask | input | NT | One bit per active thread |
| alloc_req | input | NT | Allocate one entry for each thread whose bit is set |
| release_req | input | NT | Release one entry for each thread whose bit is set |
| squash_vld | input | 1 | Squash request valid |
| squash_tid | input | TW | Thread that the squash applies to |
| squash_cnt | input | CW | Number of entries the squash removes |
| free_cnt | output | NT*CW | Free count of each thread; thread t occupies bits [t*CW +: CW] |
| thread_full | output | NT | Per-thread full flags |
| queue_full | output | 1 | The whole queue is occupied |
| alloc_err | output | 1 | An allocate was refused in the previous cycle |

## Verification
Every output comes from a register, so every result is due exactly one rising edge after the stimulus that causes it. The bench changes inputs at the falling edge and compares all outputs with its own model at the next falling edge. The model steps once per edge, from the same inputs that edge sampled. For R5, one extra check reads a free count in the middle of the cycle in which the mode changed, before the edge. It confirms that the old cap still applies at that point.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;
  typedef enum logic [1:0] {
    SHARE_ALL   = 2'd0,
    SHARE_SPLIT = 2'd1,
    SHARE_PCT   = 2'd2,
    SHARE_RSVD  = 2'd3
  } share_mode_e;
endpackage

// File: rtl/iq_cap_calc.sv
module iq_cap_calc
  import iq_alloc_pkg::*;
#(
  parameter int NT    = 4,
  parameter int TOTAL = 32,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode,
  input  logic [6:0]             pct,
  input  logic [NT-1:0]          act_mask,
  output logic [NT-1:0][CW-1:0]  cap_q
);
  localparam int PW      = CW + 7;
  localparam int STATIC  = TOTAL / NT;

  logic [NT-1:0][CW-1:0] cap_d;
  logic [6:0]            pct_c;
  logic [PW-1:0]         thr_prod;
  logic [CW-1:0]         thr_cap;
  logic [CW-1:0]         split_cap;
  int                    n_act;

  always_comb begin
    n_act = 0;
    for (int i = 0; i < NT; i++) n_act = n_act + int'(act_mask[i]);
    pct_c     = (pct > 7'd100) ? 7'd100 : pct;
    thr_prod  = PW'(pct_c) * PW'(TOTAL);
    thr_cap   = CW'(thr_prod / PW'(100));
    split_cap = (n_act == 0) ? CW'(STATIC) : CW'(TOTAL / n_act);
    for (int t = 0; t < NT; t++) begin
      case (share_mode_e'(mode))
        SHARE_SPLIT: begin
          if (n_act == 0)       cap_d[t] = cap_q[t];
          else if (act_mask[t]) cap_d[t] = split_cap;
          else                  cap_d[t] = CW'(STATIC);
        end
        SHARE_PCT: begin
          if (n_act == 1 && act_mask[t]) cap_d[t] = CW'(TOTAL);
          else                           cap_d[t] = thr_cap;
        end
        default: cap_d[t] = CW'(TOTAL);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) cap_q[t] <= CW'(STATIC);
    end else begin
      cap_q <= cap_d;
    end
  end

  generate
    for (genvar g = 0; g < NT; g++) begin : g_cap_chk
      // R4
      cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q[g] <= CW'(TOTAL));
    end
  endgenerate

  // R3
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && act_mask == '0) |=> $stable(cap_q));
endmodule

// File: rtl/iq_grant.sv
module iq_grant #(
  parameter int NT = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] alloc_req,
  input  logic [NT-1:0] thr_full,
  input  logic [CW-1:0] room,
  output logic [NT-1:0] grant,
  output logic          refuse
);
  logic [CW-1:0] left;

  always_comb begin
    left   = room;
    grant  = '0;
    refuse = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (alloc_req[t]) begin
        if (!thr_full[t] && left != '0) begin
          grant[t] = 1'b1;
          left     = left - CW'(1);
        end else begin
          refuse = 1'b1;
        end
      end
    end
  end

  // R7
  grant_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'($countones(grant)) <= room);
endmodule

// File: rtl/iq_thread_occ.sv
module iq_thread_occ #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          rel,
  input  logic [CW-1:0] sq_amt,
  input  logic [CW-1:0] cap,
  output logic [CW-1:0] occ_q,
  output logic [CW-1:0] free_o,
  output logic          full_o
);
  logic [CW:0]   dec_w;
  logic [CW-1:0] dec;

  always_comb begin
    dec_w  = {1'b0, sq_amt} + (CW+1)'(rel);
    dec    = (dec_w > {1'b0, occ_q}) ? occ_q : dec_w[CW-1:0];
    free_o = (cap > occ_q) ? (cap - occ_q) : '0;
    full_o = (free_o == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q - dec + CW'(inc);
  end

  // R7
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q > $past(occ_q)) |-> (occ_q == $past(occ_q) + CW'(1)));

  // R8
  grant_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !full_o);
endmodule

// File: rtl/iq_entry_alloc.sv
module iq_entry_alloc #(
  parameter int NT    = 4,
  parameter int TOTAL = 32,
  parameter int CW    = $clog2(TOTAL + 1),
  parameter int TW    = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       share_mode,
  input  logic [6:0]       thresh_pct,
  input  logic [NT-1:0]    active_mask,
  input  logic [NT-1:0]    alloc_req,
  input  logic [NT-1:0]    release_req,
  input  logic             squash_vld,
  input  logic [TW-1:0]    squash_tid,
  input  logic [CW-1:0]    squash_cnt,
  output logic [NT*CW-1:0] free_cnt,
  output logic [NT-1:0]    thread_full,
  output logic             queue_full,
  output logic             alloc_err
);
  localparam int SW = CW + TW + 1;

  logic [NT-1:0][CW-1:0] cap;
  logic [NT-1:0][CW-1:0] occ;
  logic [NT-1:0][CW-1:0] tfree;
  logic [NT-1:0]         grant;
  logic                  refuse;
  logic [SW-1:0]         occ_sum;
  logic [CW-1:0]         room;

  iq_cap_calc #(.NT(NT), .TOTAL(TOTAL), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(share_mode), .pct(thresh_pct),
    .act_mask(active_mask), .cap_q(cap)
  );

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NT; t++) occ_sum = occ_sum + SW'(occ[t]);
    room       = (occ_sum >= SW'(TOTAL)) ? '0 : CW'(SW'(TOTAL) - occ_sum);
    queue_full = (occ_sum >= SW'(TOTAL));
  end

  iq_grant #(.NT(NT), .CW(CW)) u_grant (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .thr_full(thread_full),
    .room(room), .grant(grant), .refuse(refuse)
  );

  generate
    for (genvar g = 0; g < NT; g++) begin : g_thr
      logic [CW-1:0] sq_amt;
      assign sq_amt = (squash_vld && squash_tid == TW'(g)) ? squash_cnt : '0;
      iq_thread_occ #(.CW(CW)) u_occ (
        .clk(clk), .rst_n(rst_n), .inc(grant[g]), .rel(release_req[g]),
        .sq_amt(sq_amt), .cap(cap[g]), .occ_q(occ[g]),
        .free_o(tfree[g]), .full_o(thread_full[g])
      );
      assign free_cnt[g*CW +: CW] = tfree[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) alloc_err <= 1'b0;
    else        alloc_err <= refuse;
  end

  // R10
  glob_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum <= SW'(TOTAL));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> $past(alloc_req != '0));
endmodule

// File: tb/test_iq_entry_alloc.sv
`timescale 1ns/1ps
module test_iq_entry_alloc;
  localparam int NT = 4, TOTAL = 32, CW = 6, TW = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] share_mode = 2'd1;
  logic [6:0] thresh_pct = 7'd50;
  logic [NT-1:0] active_mask = 4'hF;
  logic [NT-1:0] alloc_req = '0, release_req = '0;
  logic squash_vld = 0;
  logic [TW-1:0] squash_tid = '0;
  logic [CW-1:0] squash_cnt = '0;
  logic [NT*CW-1:0] free_cnt;
  logic [NT-1:0] thread_full;
  logic queue_full, alloc_err;

  int n_chk = 0, n_fail = 0;
  int m_cap[NT], m_occ[NT];
  bit m_err;
  bit done = 0;

  always #10 clk = ~clk;

  iq_entry_alloc #(.NT(NT), .TOTAL(TOTAL)) i_iq_entry_alloc (
    .clk(clk), .rst_n(rst_n), .share_mode(share_mode), .thresh_pct(thresh_pct),
    .active_mask(active_mask), .alloc_req(alloc_req), .release_req(release_req),
    .squash_vld(squash_vld), .squash_tid(squash_tid), .squash_cnt(squash_cnt),
    .free_cnt(free_cnt), .thread_full(thread_full), .queue_full(queue_full),
    .alloc_err(alloc_err)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int fr(input int t);
    return (m_cap[t] > m_occ[t]) ? m_cap[t] - m_occ[t] : 0;
  endfunction

  function automatic int dut_free(input int t);
    return int'(free_cnt[t*CW +: CW]);
  endfunction

  function automatic int new_cap(input int t);
    int n = $countones(active_mask);
    int p = (thresh_pct > 100) ? 100 : int'(thresh_pct);
    if (share_mode == 2'd1) begin
      if (n == 0) return m_cap[t];
      return active_mask[t] ? TOTAL / n : TOTAL / NT;
    end
    if (share_mode == 2'd2) begin
      if (n == 1 && active_mask[t]) return TOTAL;
      return (p * TOTAL) / 100;
    end
    return TOTAL;
  endfunction

  task automatic check_all();
    int s = 0;
    for (int t = 0; t < NT; t++) begin
      chk("R6 free", dut_free(t), fr(t));
      chk("R6 full", int'(thread_full[t]), int'(fr(t) == 0));
      s += m_occ[t];
    end
    chk("R10 queue_full", int'(queue_full), int'(s == TOTAL));
    chk("R8 alloc_err", int'(alloc_err), int'(m_err));
  endtask

  task automatic step(input logic [3:0] a, input logic [3:0] r,
                      input bit sv, input int st, input int sc);
    int nc[NT];
    int room = TOTAL;
    bit g[NT];
    alloc_req = a; release_req = r; squash_vld = sv;
    squash_tid = TW'(st); squash_cnt = CW'(sc);
    for (int t = 0; t < NT; t++) begin nc[t] = new_cap(t); room -= m_occ[t]; end
    m_err = 0;
    for (int t = 0; t < NT; t++) begin
      g[t] = 0;
      if (a[t]) begin
        if (fr(t) > 0 && room > 0) begin g[t] = 1; room--; end
        else m_err = 1;
      end
    end
    for (int t = 0; t < NT; t++) begin
      int d = int'(r[t]) + ((sv && st == t) ? sc : 0);
      if (d > m_occ[t]) d = m_occ[t];
      m_occ[t] = m_occ[t] - d + int'(g[t]);
      m_cap[t] = nc[t];
    end
    @(posedge clk); #1;
    alloc_req = '0; release_req = '0; squash_vld = 0;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int t = 0; t < NT; t++) begin m_cap[t] = TOTAL / NT; m_occ[t] = 0; end
    m_err = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int t = 0; t < NT; t++) chk("R1 reset free", dut_free(t), 8);
    chk("R1 reset full", int'(thread_full), 0);
    chk("R1 reset queue_full", int'(queue_full), 0);
    chk("R1 reset err", int'(alloc_err), 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0);

    // R5: change not visible before the edge
    share_mode = 2'd0;
    #2 chk("R5 before edge", dut_free(0), 8);
    step(0, 0, 0, 0, 0);
    chk("R2 whole-queue cap", dut_free(0), 32);
    share_mode = 2'd3;
    step(0, 0, 0, 0, 0);
    chk("R2 code 3 cap", dut_free(3), 32);

    // R7: ascending order for last global room
    repeat (30) step(4'b0001, 0, 0, 0, 0);
    step(4'b1111, 0, 0, 0, 0);
    chk("R7 t0 granted", dut_free(0), 1);
    chk("R7 t1 granted", dut_free(1), 31);
    chk("R7 t2 refused", dut_free(2), 32);
    chk("R8 err on refusal", int'(alloc_err), 1);
    chk("R10 full", int'(queue_full), 1);
    step(4'b0100, 0, 0, 0, 0);
    chk("R8 refused no change", dut_free(2), 32);
    chk("R8 err again", int'(alloc_err), 1);

    // R9: squash clamps at occupancy
    step(0, 4'b0001, 1, 0, 40);
    chk("R9 squash clamp", dut_free(0), 32);
    step(0, 4'b0010, 0, 0, 0);
    step(4'b0010, 4'b0010, 0, 0, 0);
    chk("R9 alloc after clamp", dut_free(1), 31);

    // R3: even split
    share_mode = 2'd1; active_mask = 4'b0011;
    step(0, 0, 0, 0, 0);
    chk("R3 active share", dut_free(0), 16);
    chk("R3 active share t1", dut_free(1), 15);
    chk("R3 inactive share", dut_free(2), 8);
    active_mask = 4'b0000;
    step(0, 0, 0, 0, 0);
    chk("R3 zero mask hold", dut_free(0), 16);
    active_mask = 4'b0111;
    step(0, 0, 0, 0, 0);
    chk("R3 three active", dut_free(0), 10);

    // R4: percentage
    share_mode = 2'd2; thresh_pct = 7'd50; active_mask = 4'hF;
    step(0, 0, 0, 0, 0);
    chk("R4 pct 50", dut_free(0), 16);
    active_mask = 4'b0001;
    step(0, 0, 0, 0, 0);
    chk("R4 single active", dut_free(0), 32);
    chk("R4 others", dut_free(2), 16);
    thresh_pct = 7'd120; active_mask = 4'hF;
    step(0, 0, 0, 0, 0);
    chk("R4 pct clamp", dut_free(3), 32);
    thresh_pct = 7'd33;
    step(0, 0, 0, 0, 0);
    chk("R4 pct truncation", dut_free(3), 10);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a, r;
      bit sv;
      if (i % 64 == 0) begin
        share_mode  = 2'($urandom);
        thresh_pct  = 7'($urandom % 128);
        active_mask = 4'($urandom);
      end
      a  = 4'($urandom) | 4'($urandom);
      r  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      sv = ($urandom % 16) == 0;
      step(a, r, sv, int'($urandom % 4), int'($urandom % 8));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule